// File: doc/BRIEF.md
# UART Receive Queue with Switchable Depth

This block is the receive-side character buffer of a UART. Each entry is twelve bits: an eight-bit character and four error flags (overrun, break, parity, framing). The queue holds up to `DEPTH` entries (16 by default) while the queue-enable input is high. It holds exactly one entry while that input is low. Any change of the queue-enable input flushes the queue.

Entries arrive on one of two valid/ready streams. The receiver stream carries deserialised characters and break events. The loopback stream carries characters and breaks from the local transmitter. The loopback-enable input picks which stream the block listens to. The unselected stream is ignored completely.

Back-pressure is lossy on purpose, as on a real line. A beat offered on the selected stream while its ready is low is not held by the source. It is discarded, and the overrun flag of the status latch is set.

A one-cycle read strobe pops the oldest entry, which is always visible on the read-entry output. On each pop, the error flags of the popped entry are copied into a status latch. The latch is cleared by a separate strobe. The block also keeps full and empty flags and a receive interrupt request driven by a fixed trigger count.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the block shows the following: `empty`=1, `full`=0, `rx_irq`=0, `stat_err`=0, `can_accept`=1, `rx_ready`=1 and `lb_ready`=0.
- R2: The capacity is `DEPTH` while `fifo_en`=1 and one entry while `fifo_en`=0. `can_accept` is high exactly while the stored count is below the capacity. `rx_ready` = `can_accept` and not `loopback_en`. `lb_ready` = `can_accept` and `loopback_en`.
- R3: Entries leave in arrival order, and `rd_entry` always shows the oldest one. The entry layout is bit 11 overrun (always stored as 0), bit 10 break, bit 9 parity, bit 8 framing, bits 7:0 character.
- R4: `full` sets when an accepted beat makes the count equal to the capacity. Any pop clears `full`. `empty` clears on an accepted beat and sets when the count returns to zero.
- R5: `rx_irq` sets when an accepted beat makes the count equal to `TRIG` (default 1). It clears when a pop leaves the count at `TRIG`-1, which includes a pop on an empty queue. If both happen in one cycle, the set wins.
- R6: A pop loads `stat_err` ({overrun, break, parity, framing}) with the four error bits of the popped entry. A `stat_clr` pulse zeroes `stat_err`.
- R7: A valid beat on the selected stream while its ready is low is discarded: the count is unchanged and `stat_err[3]` (overrun) sets.
- R8: Beats on the stream not selected by `loopback_en` have no effect on the count, the flags or `stat_err`.
- R9: A beat with its break input high is stored with character 0x00 and the break bit set, whatever its data bits carry.
- R10: A change of `fifo_en` empties the queue (count 0, `empty`=1, `full`=0) and leaves `rx_irq` unchanged.
- R11: A pop and an accepted beat in the same cycle on a non-empty queue leave the count unchanged. The old head leaves and the new beat joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: queue of DEPTH entries, 0: single holding entry |
| loopback_en | input | 1 | Selects the loopback stream instead of the receiver stream |
| rx_valid | input | 1 | Receiver beat offered |
| rx_ready | output | 1 | Receiver beat will be stored |
| rx_data | input | 8 | Receiver character |
| rx_frm_err | input | 1 | Framing error for this beat |
| rx_par_err | input | 1 | Parity error for this beat |
| rx_brk | input | 1 | Beat is a break event |
| lb_valid | input | 1 | Loopback beat offered |
| lb_ready | output | 1 | Loopback beat will be stored |
| lb_data | input | 8 | Loopback character |
| lb_brk | input | 1 | Loopback beat is a break |
| rd_stb | input | 1 | Pop the oldest entry this cycle |
| rd_entry | output | 12 | Oldest entry, layout per R3 |
| stat_clr | input | 1 | Zero the error status latch |
| stat_err | output | 4 | Error status latch {overrun, break, parity, framing} |
| can_accept | output | 1 | Count below current capacity |
| full | output | 1 | Full flag |
| empty | output | 1 | Empty flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A pop and a push can fall in the same cycle, and the block has to resolve the pair as pop-first for both the count and the interrupt. The bench drives a receiver beat and a read strobe on the same edge while one entry is stored. It then checks that the count (seen through `empty`, `full` and `can_accept`) is unchanged and that `rx_irq` stays high. It also checks that the scoreboard sees the old head leave first and the new character surface next.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int CHAR_W  = 8;
  localparam int ERR_W   = 4;
  localparam int ENTRY_W = CHAR_W + ERR_W;

  typedef struct packed {
    logic ovr;
    logic brk;
    logic par;
    logic frm;
  } rxq_err_t;

  typedef struct packed {
    rxq_err_t           err;
    logic [CHAR_W-1:0]  data;
  } rxq_entry_t;
endpackage

// File: rtl/uart_rxq_ingress.sv
module uart_rxq_ingress
  import uart_rxq_pkg::*;
(
  input  logic              loopback_en,
  input  logic              can_accept,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_frm_err,
  input  logic              rx_par_err,
  input  logic              rx_brk,
  input  logic              lb_valid,
  input  logic [CHAR_W-1:0] lb_data,
  input  logic              lb_brk,
  output logic              rx_ready,
  output logic              lb_ready,
  output logic              push_req,
  output logic              drop,
  output rxq_entry_t        push_entry
);
  rxq_entry_t rx_form, lb_form;
  logic       sel_valid;

  // Break beats carry a zero character with only the break flag set.
  always_comb begin
    rx_form          = '0;
    rx_form.err.brk  = rx_brk;
    rx_form.err.frm  = rx_frm_err & ~rx_brk;
    rx_form.err.par  = rx_par_err & ~rx_brk;
    rx_form.data     = rx_brk ? '0 : rx_data;
    lb_form          = '0;
    lb_form.err.brk  = lb_brk;
    lb_form.data     = lb_brk ? '0 : lb_data;
  end

  assign rx_ready   = can_accept & ~loopback_en;
  assign lb_ready   = can_accept &  loopback_en;
  assign sel_valid  = loopback_en ? lb_valid : rx_valid;
  assign push_req   = sel_valid & can_accept;
  assign drop       = sel_valid & ~can_accept;
  assign push_entry = loopback_en ? lb_form : rx_form;
endmodule

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_slot,
  input  rxq_entry_t    wr_entry,
  input  logic [AW-1:0] rd_slot,
  output rxq_entry_t    rd_entry
);
  rxq_entry_t slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wr_slot == AW'(i)) slot_q[i] <= wr_entry;
    end
  end

  assign rd_entry = slot_q[rd_slot];
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl #(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          wr_en,
  output logic [AW-1:0] wr_slot,
  output logic [AW-1:0] rd_slot,
  output logic          can_accept,
  output logic          pop_eff,
  output logic          full,
  output logic          empty,
  output logic          irq
);
  logic          mode_q, flush;
  logic [CW-1:0] cnt_q, cnt_after_pop, cnt_next, depth_cur;
  logic [AW-1:0] pos_q, pos_next, mask;
  logic          full_next, empty_next, irq_next;

  assign flush      = fifo_en ^ mode_q;
  assign depth_cur  = fifo_en ? CW'(DEPTH) : CW'(1);
  assign mask       = fifo_en ? AW'(DEPTH - 1) : '0;
  assign can_accept = (cnt_q < depth_cur) & ~flush;
  assign pop_eff    = pop_req & ~flush;
  assign wr_en      = push_req;
  assign wr_slot    = (pos_q + cnt_q[AW-1:0]) & mask;
  assign rd_slot    = pos_q;

  always_comb begin
    cnt_after_pop = cnt_q;
    pos_next      = pos_q;
    if (pop_eff && cnt_q != '0) begin
      cnt_after_pop = cnt_q - CW'(1);
      pos_next      = (pos_q + AW'(1)) & mask;
    end
    cnt_next   = cnt_after_pop + CW'(push_req);
    full_next  = full;
    empty_next = empty;
    irq_next   = irq;
    // Pop is applied first, then the push.
    if (pop_eff) begin
      full_next = 1'b0;
      if (cnt_after_pop == '0) empty_next = 1'b1;
      if (cnt_after_pop + CW'(1) == CW'(TRIG)) irq_next = 1'b0;
    end
    if (push_req) begin
      empty_next = 1'b0;
      if (cnt_next == depth_cur) full_next = 1'b1;
      if (cnt_next == CW'(TRIG)) irq_next = 1'b1;
    end
    if (flush) begin
      cnt_next   = '0;
      pos_next   = '0;
      full_next  = 1'b0;
      empty_next = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      cnt_q  <= '0;
      pos_q  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
      irq    <= 1'b0;
    end else begin
      mode_q <= fifo_en;
      cnt_q  <= cnt_next;
      pos_q  <= pos_next;
      full   <= full_next;
      empty  <= empty_next;
      irq    <= irq_next;
    end
  end

  // R4: empty flag agrees with the count
  a_r4_empty_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (cnt_q == '0));
  // R4: full flag agrees with the count outside a flush cycle
  a_r4_full_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !flush) |-> cnt_q == depth_cur);
  // R2: count never exceeds the capacity
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> cnt_q <= depth_cur);
  // R4: a pop always drops the full flag
  a_r4_pop_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    pop_eff |=> !full);
  // R11: simultaneous push and pop keep the count
  a_r11_pushpop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pop_eff && cnt_q != '0) |=> cnt_q == $past(cnt_q));
  // R5: the interrupt only rises after an accepted beat
  a_r5_irq_rise_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_en));
  // R10: a mode change leaves the queue empty
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !full));
endmodule

// File: rtl/uart_rxq_status.sv
module uart_rxq_status
  import uart_rxq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     pop,
  input  rxq_err_t pop_err,
  input  logic     drop,
  output rxq_err_t stat
);
  rxq_err_t stat_next;

  always_comb begin
    stat_next = stat;
    if (clr) stat_next = '0;
    if (pop) stat_next = pop_err;
    if (drop) stat_next.ovr = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_next;
  end

  // R7: a discarded beat raises the overrun flag
  a_r7_drop_sets_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> stat.ovr);
  // R6: a pop loads the popped entry's error bits
  a_r6_pop_copies_err: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !drop) |=> stat == $past(pop_err));
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en,
  input  logic               loopback_en,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [CHAR_W-1:0]  rx_data,
  input  logic               rx_frm_err,
  input  logic               rx_par_err,
  input  logic               rx_brk,
  input  logic               lb_valid,
  output logic               lb_ready,
  input  logic [CHAR_W-1:0]  lb_data,
  input  logic               lb_brk,
  input  logic               rd_stb,
  output logic [ENTRY_W-1:0] rd_entry,
  input  logic               stat_clr,
  output logic [ERR_W-1:0]   stat_err,
  output logic               can_accept,
  output logic               full,
  output logic               empty,
  output logic               rx_irq
);
  logic          push_req, drop, wr_en, pop_eff;
  logic [AW-1:0] wr_slot, rd_slot;
  rxq_entry_t    push_entry, head;
  rxq_err_t      stat;

  uart_rxq_ingress u_ingress (
    .loopback_en (loopback_en), .can_accept (can_accept),
    .rx_valid    (rx_valid),    .rx_data    (rx_data),
    .rx_frm_err  (rx_frm_err),  .rx_par_err (rx_par_err),
    .rx_brk      (rx_brk),      .lb_valid   (lb_valid),
    .lb_data     (lb_data),     .lb_brk     (lb_brk),
    .rx_ready    (rx_ready),    .lb_ready   (lb_ready),
    .push_req    (push_req),    .drop       (drop),
    .push_entry  (push_entry)
  );

  uart_rxq_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctrl (
    .clk        (clk),        .rst_n   (rst_n),
    .fifo_en    (fifo_en),    .push_req(push_req),
    .pop_req    (rd_stb),     .wr_en   (wr_en),
    .wr_slot    (wr_slot),    .rd_slot (rd_slot),
    .can_accept (can_accept), .pop_eff (pop_eff),
    .full       (full),       .empty   (empty),
    .irq        (rx_irq)
  );

  uart_rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),     .wr_en   (wr_en),
    .wr_slot  (wr_slot), .wr_entry(push_entry),
    .rd_slot  (rd_slot), .rd_entry(head)
  );

  uart_rxq_status u_status (
    .clk   (clk),     .rst_n  (rst_n),
    .clr   (stat_clr), .pop   (pop_eff),
    .pop_err(head.err), .drop (drop),
    .stat  (stat)
  );

  assign rd_entry = head;
  assign stat_err = stat;
endmodule

// File: tb/uart_rx_queue_tb_top.sv
`timescale 1ns/1ps
module uart_rx_queue_tb_top;
  localparam int DEPTH = 16;
  localparam int TRIG  = 1;

  logic clk = 0, rst_n = 0;
  logic fifo_en = 0, loopback_en = 0;
  logic rx_valid = 0, rx_frm_err = 0, rx_par_err = 0, rx_brk = 0;
  logic [7:0] rx_data = 0, lb_data = 0;
  logic lb_valid = 0, lb_brk = 0, rd_stb = 0, stat_clr = 0;
  logic rx_ready, lb_ready, can_accept, full, empty, rx_irq;
  logic [11:0] rd_entry;
  logic [3:0]  stat_err;

  always #2 clk = ~clk;

  uart_rx_queue #(.DEPTH(DEPTH), .TRIG(TRIG)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .loopback_en(loopback_en),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_frm_err(rx_frm_err), .rx_par_err(rx_par_err), .rx_brk(rx_brk),
    .lb_valid(lb_valid), .lb_ready(lb_ready), .lb_data(lb_data), .lb_brk(lb_brk),
    .rd_stb(rd_stb), .rd_entry(rd_entry), .stat_clr(stat_clr), .stat_err(stat_err),
    .can_accept(can_accept), .full(full), .empty(empty), .rx_irq(rx_irq)
  );

  int n_checks = 0, n_fail = 0;
  logic [11:0] expq [$];
  int   mcnt = 0, mdepth = 1;
  bit   mirq = 0, mfull = 0, stat_known = 1, pop_has_data = 0;
  logic [3:0] mstat = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each popped entry with the queue head.
  initial forever begin
    @(negedge clk); #1;
    if (rd_stb && pop_has_data) begin
      chk("R3 popped entry order/layout", rd_entry, expq[0]);
      void'(expq.pop_front());
    end
  end

  // Driver: one cycle of stimulus plus the reference model.
  task automatic drive(input bit rxv, input logic [7:0] rd, input bit rf, input bit rp, input bit rb,
                       input bit lbv, input logic [7:0] ld, input bit lbb, input bit pop);
    int pre;
    bit selv;
    logic [11:0] ent;
    @(negedge clk);
    rx_valid = rxv; rx_data = rd; rx_frm_err = rf; rx_par_err = rp; rx_brk = rb;
    lb_valid = lbv; lb_data = ld; lb_brk = lbb; rd_stb = pop;
    pre = mcnt;
    pop_has_data = pop && (pre > 0);
    if (pop) begin
      mfull = 0;
      if (pre > 0) begin mstat = expq[0][11:8]; stat_known = 1; mcnt--; end
      else stat_known = 0;
      if (mcnt + 1 == TRIG) mirq = 0;
    end
    selv = loopback_en ? lbv : rxv;
    if (loopback_en) ent = {2'b00, lbb, 1'b0, 1'b0, 1'b0, lbb ? 8'h00 : ld} ;
    else ent = {1'b0, rb, rb ? 1'b0 : rp, rb ? 1'b0 : rf, rb ? 8'h00 : rd};
    if (loopback_en) ent = {1'b0, lbb, 2'b00, lbb ? 8'h00 : ld};
    if (selv) begin
      if (pre < mdepth) begin
        expq.push_back(ent); mcnt++;
        if (mcnt == mdepth) mfull = 1;
        if (mcnt == TRIG) mirq = 1;
      end else mstat[3] = 1;
    end
    @(negedge clk);
    rx_valid = 0; lb_valid = 0; rd_stb = 0; rx_brk = 0; lb_brk = 0;
  endtask

  task automatic push_rx(input logic [7:0] d, input bit f, input bit p, input bit b);
    drive(1, d, f, p, b, 0, 0, 0, 0);
  endtask
  task automatic push_lb(input logic [7:0] d, input bit b);
    drive(0, 0, 0, 0, 0, 1, d, b, 0);
  endtask
  task automatic pop1();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic set_mode(input bit en);
    @(negedge clk); fifo_en = en;
    @(negedge clk);
    mcnt = 0; mfull = 0; expq.delete(); mdepth = en ? DEPTH : 1;
  endtask

  task automatic clr_stat();
    @(negedge clk); stat_clr = 1;
    @(negedge clk); stat_clr = 0; mstat = 0; stat_known = 1;
  endtask

  task automatic check_state(input string req);
    chk({req, " empty"}, empty, mcnt == 0);
    chk({req, " full"}, full, mfull);
    chk({req, " rx_irq"}, rx_irq, mirq);
    chk({req, " can_accept"}, can_accept, mcnt < mdepth);
    chk({req, " rx_ready"}, rx_ready, (mcnt < mdepth) && !loopback_en);
    chk({req, " lb_ready"}, lb_ready, (mcnt < mdepth) && loopback_en);
    if (stat_known) chk({req, " stat_err"}, stat_err, mstat);
  endtask

  initial begin
    #(200000 * 4);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1 reset");

    // Single-entry mode
    push_rx(8'h41, 1, 0, 0);
    check_state("R2 R4 R5 depth1 hold");
    push_rx(8'h42, 0, 0, 0);
    check_state("R7 depth1 overrun drop");
    pop1();
    check_state("R6 status from popped entry");
    push_rx(8'h43, 0, 1, 0);
    set_mode(1);
    check_state("R10 flush keeps irq");
    pop1();
    check_state("R5 pop on empty clears irq");
    clr_stat();
    check_state("R6 status clear");

    // Full queue mode with wrap
    for (int i = 0; i < DEPTH; i++) push_rx(8'h10 + 8'(i), i[0], i[1], 0);
    check_state("R2 R4 queue full");
    push_rx(8'hEE, 0, 0, 0);
    check_state("R7 overrun when full");
    pop1();
    check_state("R4 pop clears full");
    push_rx(8'h5A, 1, 1, 0);
    for (int i = 0; i < DEPTH - 1; i++) pop1();
    check_state("R5 irq held above trigger");
    pop1();
    check_state("R3 R4 drained");

    // Simultaneous push and pop
    push_rx(8'h61, 0, 0, 0);
    drive(1, 8'h62, 0, 1, 0, 0, 0, 0, 1);
    check_state("R11 push and pop same cycle");
    pop1();
    check_state("R11 second entry out");

    // Receiver break beat
    push_rx(8'hFF, 1, 1, 1);
    pop1();
    check_state("R9 receiver break entry");

    // Loopback selection
    @(negedge clk); loopback_en = 1;
    clr_stat();
    push_rx(8'h77, 1, 0, 0);
    check_state("R8 receiver ignored in loopback");
    push_lb(8'h88, 0);
    push_lb(8'h99, 1);
    pop1();
    pop1();
    check_state("R9 loopback break entry");
    @(negedge clk); loopback_en = 0;
    push_lb(8'h55, 0);
    check_state("R8 loopback ignored when off");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule